// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block is a byte-wide data cache for a 16-bit address space. It holds 256 sets, and each set has two ways of 8-byte lines. A way keeps a tag, a valid flag and a dirty flag. On every access the tags of both ways in the addressed set are compared at the same time. The hit vector then steers a two-input line multiplexer, and the addressed byte is taken from the selected line. Each set has one replacement bit that always names the way that was not used last.

Stores go only into the cache and mark the line dirty. A miss runs a short sequence through the line-wide memory port. If the chosen victim is dirty, the sequence first writes the victim out. It then reads the missing line in and finally answers the requester. A clean victim is overwritten without any memory write. A store miss allocates the line and merges the byte into the line as it is filled.

The requester presents one access while `cpu_ready` is high. The answer appears on `resp_valid`/`resp_rdata` one cycle after a hit, or one cycle after the memory acknowledges the refill.

Top module: `cache2w`

## Requirements
- R1: The address is split as tag = bits [15:11], set = bits [10:3], byte offset = bits [2:0]. A read returns the byte of the line at that offset, with line byte k on bits [8k+7:8k] of a memory line.
- R2: A request accepted on a hit raises `resp_valid` in the following cycle and causes no memory request.
- R3: A miss whose victim is invalid or clean issues exactly one line read (`mem_we`=0) and no line write.
- R4: A miss whose victim is valid and dirty first writes that line to memory (`mem_we`=1, `mem_addr` = {victim tag, set}, with its current contents), and only then reads the new line.
- R5: When both ways of a set are valid, a miss evicts the way that was not the most recently hit or filled in that set.
- R6: A store hit changes only the cached byte, with no memory traffic. The stored value survives eviction and a later refill.
- R7: A store miss fills the line from memory and then merges the stored byte into it. The response carries the stored byte, and a later read hits with that value.
- R8: `cpu_ready` is low from the cycle after a miss is accepted until the sequence ends. A `req_valid` during that time is ignored and changes no stored byte.
- R9: After reset all lines are invalid, `cpu_ready` is 1, and `resp_valid` and `mem_req` are 0.
- R10: Once raised, `mem_req` stays high, with `mem_addr` and `mem_we` unchanged, until `mem_ack`. After a writeback acknowledge, the next cycle carries the refill read.
- R11: An invalid way is filled before any valid way is replaced, so two tags in one set are held at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = store byte, 0 = load byte |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Store data |
| cpu_ready | output | 1 | Request is taken this cycle when high |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 8 | Loaded byte, or the stored byte for a store |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | 1 = line writeback, 0 = line read |
| mem_addr | output | 13 | Line address {tag, set} |
| mem_wline | output | 64 | Line written back |
| mem_ack | input | 1 | Memory completes the transfer this cycle |
| mem_rline | input | 64 | Line returned on a read acknowledge |

## Verification
The checker watches on every cycle that memory requests are held steady until acknowledged, and that a writeback acknowledge is always followed by a refill read. It also checks that a refill acknowledge produces a response, that no response overlaps memory traffic, and that the cache never signals ready while a miss is in progress. Replacement choice, dirty tracking and data correctness can only be shown by the bench's per-set access sequences. These include which victim is evicted, whether a writeback happens, and whether stored bytes survive eviction. The bench compares every returned byte and every memory transfer count against a model computed from addresses.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
    localparam int ADDR_W  = 16;
    localparam int TAG_W   = 5;
    localparam int IDX_W   = 8;
    localparam int OFF_W   = 3;
    localparam int BYTE_W  = 8;
    localparam int LINE_W  = BYTE_W << OFF_W;
    localparam int LADDR_W = TAG_W + IDX_W;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WRITEBACK = 2'd1,
        ST_REFILL    = 2'd2,
        ST_RESPOND   = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/cache2w_way_store.sv
module cache2w_way_store #(
    parameter int TAG_W  = 5,
    parameter int IDX_W  = 8,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_dirty,
    input  logic [LINE_W-1:0] wr_line
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [LINE_W-1:0] line_mem [SETS];
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            line_mem[wr_idx] <= wr_line;
        end
    end

    assign rd_tag   = tag_mem[rd_idx];
    assign rd_line  = line_mem[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             victim,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             used_way
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0] older_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            older_q <= '0;
        else if (upd_en)
            older_q[upd_idx] <= ~used_way;
    end

    assign victim = older_q[rd_idx];
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int A_W   = ADDR_W,
    parameter int T_W   = TAG_W,
    parameter int I_W   = IDX_W,
    parameter int O_W   = OFF_W,
    parameter int B_W   = BYTE_W,
    localparam int L_W  = B_W << O_W,
    localparam int NWAY = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [A_W-1:0]            req_addr,
    input  logic [B_W-1:0]            req_wdata,
    output logic                      cpu_ready,
    output logic                      resp_valid,
    output logic [B_W-1:0]            resp_rdata,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [T_W+I_W-1:0]        mem_addr,
    output logic [L_W-1:0]            mem_wline,
    input  logic                      mem_ack,
    input  logic [L_W-1:0]            mem_rline,
    output logic [I_W-1:0]            look_idx,
    input  logic [NWAY-1:0][T_W-1:0]  way_tag,
    input  logic [NWAY-1:0]           way_valid,
    input  logic [NWAY-1:0]           way_dirty,
    input  logic [NWAY-1:0][L_W-1:0]  way_line,
    input  logic                      lru_victim,
    output logic [NWAY-1:0]           wr_en,
    output logic [T_W-1:0]            wr_tag,
    output logic                      wr_dirty,
    output logic [L_W-1:0]            wr_line,
    output logic                      lru_upd_en,
    output logic                      lru_used
);
    typedef struct packed {
        ctl_state_e     state;
        logic [A_W-1:0] addr;
        logic           wr;
        logic [B_W-1:0] wdata;
        logic           way;
        logic           resp_valid;
        logic [B_W-1:0] resp_data;
    } ctl_regs_t;

    ctl_regs_t q, d;

    logic [A_W-1:0]  cur_addr;
    logic [T_W-1:0]  cur_tag;
    logic [O_W-1:0]  cur_off;
    logic [NWAY-1:0] hit;
    logic            hit_way;
    logic [L_W-1:0]  hit_line;
    logic            victim;

    function automatic logic [L_W-1:0] put_byte(input logic [L_W-1:0] line,
                                                input logic [O_W-1:0] off,
                                                input logic [B_W-1:0] b);
        logic [L_W-1:0] r;
        r = line;
        r[off*B_W +: B_W] = b;
        return r;
    endfunction

    assign cur_addr = (q.state == ST_IDLE) ? req_addr : q.addr;
    assign cur_tag  = cur_addr[A_W-1 -: T_W];
    assign look_idx = cur_addr[O_W +: I_W];
    assign cur_off  = cur_addr[O_W-1:0];

    for (genvar w = 0; w < NWAY; w++) begin : g_cmp
        assign hit[w] = way_valid[w] && (way_tag[w] == cur_tag);
    end

    assign hit_way  = hit[1];
    assign hit_line = hit[1] ? way_line[1] : way_line[0];
    assign victim   = !way_valid[0] ? 1'b0 : (!way_valid[1] ? 1'b1 : lru_victim);

    always_comb begin
        d          = q;
        d.resp_valid = 1'b0;
        wr_en      = '0;
        wr_tag     = cur_tag;
        wr_dirty   = 1'b0;
        wr_line    = hit_line;
        lru_upd_en = 1'b0;
        lru_used   = hit_way;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = {cur_tag, look_idx};
        mem_wline  = way_line[q.way];
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (|hit) begin
                        d.resp_valid = 1'b1;
                        d.resp_data  = req_write ? req_wdata : hit_line[cur_off*B_W +: B_W];
                        lru_upd_en   = 1'b1;
                        if (req_write) begin
                            wr_en[hit_way] = 1'b1;
                            wr_dirty       = 1'b1;
                            wr_line        = put_byte(hit_line, cur_off, req_wdata);
                        end
                    end else begin
                        d.addr  = req_addr;
                        d.wr    = req_write;
                        d.wdata = req_wdata;
                        d.way   = victim;
                        d.state = (way_valid[victim] && way_dirty[victim]) ? ST_WRITEBACK
                                                                           : ST_REFILL;
                    end
                end
            end
            ST_WRITEBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {way_tag[q.way], look_idx};
                if (mem_ack) d.state = ST_REFILL;
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    wr_en[q.way] = 1'b1;
                    wr_dirty     = q.wr;
                    wr_line      = q.wr ? put_byte(mem_rline, cur_off, q.wdata) : mem_rline;
                    lru_upd_en   = 1'b1;
                    lru_used     = q.way;
                    d.resp_valid = 1'b1;
                    d.resp_data  = q.wr ? q.wdata : mem_rline[cur_off*B_W +: B_W];
                    d.state      = ST_RESPOND;
                end
            end
            ST_RESPOND: d.state = ST_IDLE;
            default:    d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state      <= ST_IDLE;
            q.addr       <= '0;
            q.wr         <= 1'b0;
            q.wdata      <= '0;
            q.way        <= 1'b0;
            q.resp_valid <= 1'b0;
            q.resp_data  <= '0;
        end else begin
            q <= d;
        end
    end

    assign cpu_ready  = (q.state == ST_IDLE);
    assign resp_valid = q.resp_valid;
    assign resp_rdata = q.resp_data;
endmodule

// File: rtl/cache2w.sv
module cache2w
    import cache2w_pkg::*;
#(
    parameter int A_W  = ADDR_W,
    parameter int T_W  = TAG_W,
    parameter int I_W  = IDX_W,
    parameter int O_W  = OFF_W,
    parameter int B_W  = BYTE_W,
    localparam int L_W = B_W << O_W,
    localparam int NWAY = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [A_W-1:0]     req_addr,
    input  logic [B_W-1:0]     req_wdata,
    output logic               cpu_ready,
    output logic               resp_valid,
    output logic [B_W-1:0]     resp_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [T_W+I_W-1:0] mem_addr,
    output logic [L_W-1:0]     mem_wline,
    input  logic               mem_ack,
    input  logic [L_W-1:0]     mem_rline
);
    logic [I_W-1:0]             look_idx;
    logic [NWAY-1:0][T_W-1:0]   way_tag;
    logic [NWAY-1:0]            way_valid;
    logic [NWAY-1:0]            way_dirty;
    logic [NWAY-1:0][L_W-1:0]   way_line;
    logic [NWAY-1:0]            wr_en;
    logic [T_W-1:0]             wr_tag;
    logic                       wr_dirty;
    logic [L_W-1:0]             wr_line;
    logic                       lru_victim;
    logic                       lru_upd_en;
    logic                       lru_used;

    for (genvar w = 0; w < NWAY; w++) begin : g_way
        cache2w_way_store #(.TAG_W(T_W), .IDX_W(I_W), .LINE_W(L_W)) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (look_idx),
            .rd_tag   (way_tag[w]),
            .rd_valid (way_valid[w]),
            .rd_dirty (way_dirty[w]),
            .rd_line  (way_line[w]),
            .wr_en    (wr_en[w]),
            .wr_idx   (look_idx),
            .wr_tag   (wr_tag),
            .wr_dirty (wr_dirty),
            .wr_line  (wr_line)
        );
    end

    cache2w_lru #(.IDX_W(I_W)) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (look_idx),
        .victim   (lru_victim),
        .upd_en   (lru_upd_en),
        .upd_idx  (look_idx),
        .used_way (lru_used)
    );

    cache2w_ctrl #(.A_W(A_W), .T_W(T_W), .I_W(I_W), .O_W(O_W), .B_W(B_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .cpu_ready  (cpu_ready),
        .resp_valid (resp_valid),
        .resp_rdata (resp_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wline  (mem_wline),
        .mem_ack    (mem_ack),
        .mem_rline  (mem_rline),
        .look_idx   (look_idx),
        .way_tag    (way_tag),
        .way_valid  (way_valid),
        .way_dirty  (way_dirty),
        .way_line   (way_line),
        .lru_victim (lru_victim),
        .wr_en      (wr_en),
        .wr_tag     (wr_tag),
        .wr_dirty   (wr_dirty),
        .wr_line    (wr_line),
        .lru_upd_en (lru_upd_en),
        .lru_used   (lru_used)
    );
endmodule

// File: rtl/cache2w_checker.sv
module cache2w_checker #(
    parameter int A_W = 16,
    parameter int B_W = 8,
    parameter int M_W = 13,
    parameter int L_W = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_write,
    input logic [A_W-1:0] req_addr,
    input logic [B_W-1:0] req_wdata,
    input logic           cpu_ready,
    input logic           resp_valid,
    input logic [B_W-1:0] resp_rdata,
    input logic           mem_req,
    input logic           mem_we,
    input logic [M_W-1:0] mem_addr,
    input logic [L_W-1:0] mem_wline,
    input logic           mem_ack,
    input logic [L_W-1:0] mem_rline
);
    // R10: a pending transfer keeps its request, direction and address
    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R4: writeback acknowledge is followed by the refill read
    assert_wb_then_refill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

    // R7: refill acknowledge produces the response
    assert_refill_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack |=> resp_valid);

    // R8: no new request is taken while memory traffic is pending
    assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    // R2: responses never coincide with memory traffic
    assert_resp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !mem_req);
endmodule

bind cache2w cache2w_checker #(.A_W(A_W), .B_W(B_W), .M_W(T_W+I_W), .L_W(L_W)) u_chk (.*);

// File: tb/tb_cache2w.sv
module tb_cache2w;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        cpu_ready, resp_valid;
    logic [7:0]  resp_rdata;
    logic        mem_req, mem_we;
    logic [12:0] mem_addr;
    logic [63:0] mem_wline;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rline = '0;

    int checks = 0;
    int fails  = 0;
    int rd_cnt = 0;
    int wb_cnt = 0;
    int cycles = 0;
    int lat    = 0;
    logic [12:0] last_wb_addr = '0;
    logic [63:0] last_wb_line = '0;
    logic [63:0] wb_mem [int];
    logic [7:0]  shadow [int];

    always #4 clk = ~clk;

    cache2w dut (.*);

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] + a[15:8] * 8'd7 + 8'h3C;
    endfunction

    function automatic logic [63:0] pat_line(input logic [12:0] la);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[k*8 +: 8] = pat({la, k[2:0]});
        return r;
    endfunction

    function automatic logic [7:0] expv(input logic [15:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : pat(a);
    endfunction

    // memory model: acknowledges on the second negedge of a request
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
            lat <= 0;
        end else if (mem_req) begin
            if (lat == 1) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    wb_mem[int'(mem_addr)] = mem_wline;
                    last_wb_addr <= mem_addr;
                    last_wb_line <= mem_wline;
                    wb_cnt <= wb_cnt + 1;
                end else begin
                    mem_rline <= wb_mem.exists(int'(mem_addr)) ? wb_mem[int'(mem_addr)]
                                                               : pat_line(mem_addr);
                    rd_cnt <= rd_cnt + 1;
                end
            end
            lat <= lat + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic acc(input bit w, input logic [15:0] a, input logic [7:0] dv,
                       input int erd, input int ewb, input string req);
        int r0, w0;
        logic [7:0] e;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        r0 = rd_cnt; w0 = wb_cnt;
        e = w ? dv : expv(a);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = dv;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid) @(negedge clk);
        chk(resp_rdata == e, req, resp_rdata, e);
        chk(rd_cnt - r0 == erd, {req, " reads"}, rd_cnt - r0, erd);
        chk(wb_cnt - w0 == ewb, {req, " writebacks"}, wb_cnt - w0, ewb);
        if (w) shadow[int'(a)] = dv;
    endtask

    function automatic logic [15:0] mk(input int t, input int s, input int o);
        return {t[4:0], s[7:0], o[2:0]};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(cpu_ready == 1'b1, "R9 ready", cpu_ready, 1);
        chk(resp_valid == 1'b0, "R9 resp", resp_valid, 0);
        chk(mem_req == 1'b0, "R9 mem_req", mem_req, 0);

        for (int s = 0; s < 256; s += 17) begin
            logic [7:0] v;
            v = 8'(s * 5 + 1);
            acc(0, mk(1, s, 0), 0, 1, 0, "R3 R1 cold read");
            acc(0, mk(1, s, 5), 0, 0, 0, "R2 R1 hit read");
            acc(0, mk(2, s, 1), 0, 1, 0, "R11 second tag fill");
            acc(0, mk(1, s, 3), 0, 0, 0, "R11 first tag kept");
            acc(1, mk(1, s, 2), v, 0, 0, "R6 store hit");
            acc(0, mk(3, s, 4), 0, 1, 0, "R5 evict older clean");
            acc(0, mk(1, s, 6), 0, 0, 0, "R5 recent way kept");
            acc(0, mk(2, s, 0), 0, 1, 0, "R5 evict other way");
            acc(0, mk(3, s, 7), 0, 1, 1, "R4 dirty writeback");
            chk(last_wb_addr == {5'd1, s[7:0]}, "R4 wb addr", last_wb_addr, {5'd1, s[7:0]});
            chk(last_wb_line[23:16] == v, "R4 wb data", last_wb_line[23:16], v);
            acc(0, mk(1, s, 2), 0, 1, 0, "R6 stored byte survives");
            acc(1, mk(4, s, 7), ~v, 1, 0, "R7 store miss allocate");
            acc(0, mk(4, s, 7), 0, 0, 0, "R7 merged byte hit");
            acc(0, mk(4, s, 1), 0, 0, 0, "R7 line rest from memory");
        end

        // R8: request during a miss is ignored
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = mk(9, 100, 0);
        @(posedge clk);
        @(negedge clk);
        chk(cpu_ready == 1'b0, "R8 busy after miss", cpu_ready, 0);
        req_write = 1'b1; req_addr = mk(10, 100, 3); req_wdata = 8'hA5;
        while (!resp_valid) @(negedge clk);
        req_valid = 1'b0;
        chk(resp_rdata == pat(mk(9, 100, 0)), "R8 miss answer", resp_rdata, pat(mk(9, 100, 0)));
        acc(0, mk(10, 100, 3), 0, 1, 0, "R8 ignored store left no trace");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule